// File: doc/BRIEF.md
# Flash Write Protection Gate

This block sits between a flash command decoder and the array sequencer and decides, for every requested program or erase, whether the operation may go ahead or must be dropped without notice. It looks at the target address, the operation kind, two active-low protection pins, a bank of per-block lock bits, a supply-good flag and, in multiplexed parallel mode, the output-enable and write-enable strobes.

The array is split into `2**BLK_BITS` equal blocks, and the block number is taken from the top `BLK_BITS` bits of the address. The highest block is the boot block. The boot-lock pin guards only the boot block. The write-protect pin guards every other block. Either pin, while active, protects its blocks whatever their lock bits say. A write-enable glitch filter qualifies a strobe only after it has stayed low for `MIN_LOW` consecutive clock samples.

Top module: `flash_wp_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `allow` and `ignore` are low.
- R2: A request sampled with `req_valid` high gives exactly one of `allow` or `ignore` high in the next cycle. A cycle with no request gives both low in the next cycle.
- R3: The target block is `addr[18:16]` and block 7 is the boot block. While `boot_lock_n` is 0, a program or block erase aimed at block 7 is ignored, whatever the lock bits hold.
- R4: While `wr_prot_n` is 0, a program or block erase aimed at blocks 0 to 6 is ignored. Block 7 is not affected by this pin.
- R5: Lock bit `lock_bits[i]` set to 1 protects block i. A program or block erase to a block protected by its lock bit or by its pin is ignored. A block with neither is allowed, provided R6 to R8 permit it.
- R6: When `supply_ok` is 0, every request is ignored.
- R7: When `mux_mode` is 1, a request is ignored if `oe_n` is 0 or `we_n` is 1 in the request cycle. When `mux_mode` is 0, `oe_n` and `we_n` have no effect.
- R8: When `mux_mode` is 1, a request is allowed only if `we_n` has been 0 at `MIN_LOW` (default 2) consecutive clock samples, counting the request sample. A shorter low run gives ignore.
- R9: Op code 2'b10 (chip erase) is allowed only when no block is protected by either pin or by any lock bit.
- R10: Op codes are 2'b00 program, 2'b01 block erase, 2'b10 chip erase and 2'b11 reserved. A reserved op is always ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A program or erase request is present this cycle |
| op | input | 2 | Operation code (see R10) |
| addr | input | ADDR_W | Target byte address |
| boot_lock_n | input | 1 | Boot block lock pin, active low |
| wr_prot_n | input | 1 | Write-protect pin for non-boot blocks, active low |
| lock_bits | input | 2**BLK_BITS | Per-block lock register bits |
| supply_ok | input | 1 | Supply above the write threshold |
| mux_mode | input | 1 | Multiplexed parallel mode is active |
| oe_n | input | 1 | Output enable strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| allow | output | 1 | Request accepted, one-cycle pulse |
| ignore | output | 1 | Request dropped, one-cycle pulse |

## Verification
The assertions assume that every input is a clean, synchronous level sampled at the rising clock edge. They also assume that the pins, lock bits and supply flag do not change within the one-cycle window between a request and its outcome, since the checker compares the outcome with the values sampled at the request edge. The stimulus changes inputs only at falling edges. It clears the write-enable low run with a high sample before each trial, so every trial starts from a known run length. All other inputs are held steady from the request edge until the outcome has been checked.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;
   typedef enum logic [1:0] {
      OP_PROG   = 2'b00,
      OP_BERASE = 2'b01,
      OP_CERASE = 2'b10,
      OP_RSVD   = 2'b11
   } wp_op_e;
endpackage

// File: rtl/wp_block_map.sv
module wp_block_map #(
   parameter int BLK_BITS = 3,
   localparam int NBLK = 1 << BLK_BITS,
   localparam int BOOT = NBLK - 1
) (
   input  logic [BLK_BITS-1:0] blk_idx,
   input  logic                boot_lock_n,
   input  logic                wr_prot_n,
   input  logic [NBLK-1:0]     lock_bits,
   output logic [NBLK-1:0]     prot_vec,
   output logic                tgt_prot
);
   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      if (b == BOOT) begin : g_boot
         assign prot_vec[b] = lock_bits[b] | ~boot_lock_n;
      end else begin : g_main
         assign prot_vec[b] = lock_bits[b] | ~wr_prot_n;
      end
   end

   assign tgt_prot = prot_vec[blk_idx];
endmodule

// File: rtl/wp_pulse_filter.sv
module wp_pulse_filter #(
   parameter int MIN_LOW = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic we_n,
   output logic we_qual
);
   if (MIN_LOW < 1) begin : g_bad
      $error("wp_pulse_filter: MIN_LOW must be at least 1");
   end

   if (MIN_LOW == 1) begin : g_direct
      assign we_qual = ~we_n;
   end else begin : g_count
      localparam int CW = $clog2(MIN_LOW) + 1;
      localparam logic [CW-1:0] SAT = CW'(MIN_LOW - 1);
      logic [CW-1:0] low_run;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               low_run <= '0;
         else if (we_n)            low_run <= '0;
         else if (low_run != SAT)  low_run <= low_run + 1'b1;
      end

      assign we_qual = ~we_n && (low_run == SAT);
   end
endmodule

// File: rtl/wp_decide.sv
module wp_decide
   import flash_wp_pkg::*;
(
   input  wp_op_e op,
   input  logic   tgt_prot,
   input  logic   any_prot,
   input  logic   supply_ok,
   input  logic   mux_mode,
   input  logic   oe_n,
   input  logic   we_qual,
   output logic   ok
);
   logic strobe_ok;
   logic target_ok;

   assign strobe_ok = ~mux_mode | (oe_n & we_qual);

   always_comb begin
      unique case (op)
         OP_PROG, OP_BERASE: target_ok = ~tgt_prot;
         OP_CERASE:          target_ok = ~any_prot;
         default:            target_ok = 1'b0;
      endcase
   end

   assign ok = supply_ok & strobe_ok & target_ok;
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
   import flash_wp_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int BLK_BITS = 3,
   parameter int MIN_LOW  = 2,
   localparam int NBLK = 1 << BLK_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic              boot_lock_n,
   input  logic              wr_prot_n,
   input  logic [NBLK-1:0]   lock_bits,
   input  logic              supply_ok,
   input  logic              mux_mode,
   input  logic              oe_n,
   input  logic              we_n,
   output logic              allow,
   output logic              ignore
);
   if (BLK_BITS < 1 || ADDR_W <= BLK_BITS) begin : g_bad
      $error("flash_wp_gate: need 1 <= BLK_BITS < ADDR_W");
   end

   logic [BLK_BITS-1:0] blk_idx;
   logic [NBLK-1:0]     prot_vec;
   logic                tgt_prot;
   logic                we_qual;
   logic                ok;
   logic                unused_low;

   assign blk_idx    = addr[ADDR_W-1 -: BLK_BITS];
   assign unused_low = ^addr[ADDR_W-BLK_BITS-1:0];

   wp_block_map #(.BLK_BITS(BLK_BITS)) u_map (
      .blk_idx     (blk_idx),
      .boot_lock_n (boot_lock_n),
      .wr_prot_n   (wr_prot_n),
      .lock_bits   (lock_bits),
      .prot_vec    (prot_vec),
      .tgt_prot    (tgt_prot)
   );

   wp_pulse_filter #(.MIN_LOW(MIN_LOW)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_n    (we_n),
      .we_qual (we_qual)
   );

   wp_decide u_dec (
      .op        (wp_op_e'(op)),
      .tgt_prot  (tgt_prot),
      .any_prot  (|prot_vec),
      .supply_ok (supply_ok),
      .mux_mode  (mux_mode),
      .oe_n      (oe_n),
      .we_qual   (we_qual),
      .ok        (ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         allow  <= 1'b0;
         ignore <= 1'b0;
      end else begin
         allow  <= req_valid & ok;
         ignore <= req_valid & ~ok;
      end
   end
endmodule

// File: rtl/wp_gate_checker.sv
module wp_gate_checker #(
   parameter int ADDR_W   = 19,
   parameter int BLK_BITS = 3,
   parameter int MIN_LOW  = 2,
   localparam int NBLK = 1 << BLK_BITS,
   localparam int BOOT = NBLK - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        op,
   input logic [ADDR_W-1:0] addr,
   input logic              boot_lock_n,
   input logic              wr_prot_n,
   input logic [NBLK-1:0]   lock_bits,
   input logic              supply_ok,
   input logic              mux_mode,
   input logic              oe_n,
   input logic              we_n,
   input logic              allow,
   input logic              ignore
);
   localparam int RW = $clog2(MIN_LOW + 1) + 1;
   logic [RW-1:0]       run_q;
   logic [BLK_BITS-1:0] blk;
   logic                lock_hit;

   assign blk      = addr[ADDR_W-1 -: BLK_BITS];
   assign lock_hit = lock_bits[blk];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        run_q <= '0;
      else if (we_n)                     run_q <= '0;
      else if (run_q < RW'(MIN_LOW))     run_q <= run_q + 1'b1;
   end

   assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({allow, ignore}));
   assert_req_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (allow || ignore));
   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(allow || ignore));
   assert_boot_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      allow |-> !($past(!boot_lock_n) && $past(blk) == BLK_BITS'(BOOT)));
   assert_wr_prot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      allow |-> !($past(!wr_prot_n) && ($past(blk) != BLK_BITS'(BOOT) || $past(op) == 2'b10)));
   assert_lock_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      allow |-> !$past(lock_hit));
   assert_supply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      allow |-> $past(supply_ok));
   assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (allow && $past(mux_mode)) |-> ($past(oe_n) && !$past(we_n)));
   assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (allow && $past(mux_mode)) |-> (run_q >= RW'(MIN_LOW)));
   assert_chip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (allow && $past(op) == 2'b10) |-> ($past(lock_bits) == '0 && $past(boot_lock_n) && $past(wr_prot_n)));
   assert_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
      allow |-> $past(op) != 2'b11);
endmodule

bind flash_wp_gate wp_gate_checker #(
   .ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS), .MIN_LOW(MIN_LOW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .addr(addr),
   .boot_lock_n(boot_lock_n), .wr_prot_n(wr_prot_n), .lock_bits(lock_bits),
   .supply_ok(supply_ok), .mux_mode(mux_mode), .oe_n(oe_n), .we_n(we_n),
   .allow(allow), .ignore(ignore)
);

// File: tb/flash_wp_gate_test.sv
`timescale 1ns/1ps
module flash_wp_gate_test;
   localparam int ADDR_W = 19, BLK_BITS = 3, MIN_LOW = 2, NBLK = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] op = 2'b00;
   logic [ADDR_W-1:0] addr = '0;
   logic boot_lock_n = 1'b1, wr_prot_n = 1'b1;
   logic [NBLK-1:0] lock_bits = '0;
   logic supply_ok = 1'b1, mux_mode = 1'b0, oe_n = 1'b1, we_n = 1'b1;
   logic allow, ignore;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flash_wp_gate uut (.*);

   function automatic bit exp_ok(logic [1:0] o, logic [2:0] b, logic bl, logic wp,
                                 logic [7:0] lk, logic sup, logic mx, logic oe, int d);
      logic [7:0] p;
      for (int i = 0; i < 8; i++) p[i] = lk[i] | ((i == 7) ? ~bl : ~wp);
      if (!sup || o == 2'b11) return 1'b0;
      if (mx && (!oe || d < MIN_LOW)) return 1'b0;
      if (o == 2'b10) return p == 8'h00;
      return !p[b];
   endfunction

   task automatic check(string tag, logic a_exp, logic i_exp);
      checks++;
      if (allow !== a_exp || ignore !== i_exp) begin
         fails++;
         $display("FAIL %s: allow/ignore=%b%b expected %b%b", tag, allow, ignore, a_exp, i_exp);
      end
   endtask

   // d = consecutive we_n low samples ending at the request edge (0 = we_n high)
   task automatic trial(string tag, logic [1:0] o, logic [2:0] b, logic bl, logic wp,
                        logic [7:0] lk, logic sup, logic mx, logic oe, int d);
      bit e;
      @(negedge clk);
      op = o; addr = {b, 16'($urandom)}; boot_lock_n = bl; wr_prot_n = wp;
      lock_bits = lk; supply_ok = sup; mux_mode = mx; oe_n = oe;
      for (int k = 0; k < d - 1; k++) begin
         we_n = 1'b0; req_valid = 1'b0;
         @(negedge clk);
      end
      we_n = (d == 0); req_valid = 1'b1;
      @(negedge clk);
      e = exp_ok(o, b, bl, wp, lk, sup, mx, oe, d);
      check(tag, e, ~e);
      req_valid = 1'b0; we_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 1'b0, 1'b0);

      trial("R3 boot pin low, lock clear", 2'b00, 3'd7, 1'b0, 1'b1, 8'h00, 1, 0, 1, 0);
      trial("R4 wp pin spares boot", 2'b01, 3'd7, 1'b1, 1'b0, 8'h00, 1, 0, 1, 0);
      trial("R4 wp pin on block 3", 2'b00, 3'd3, 1'b1, 1'b0, 8'h00, 1, 0, 1, 0);
      trial("R3 boot pin spares block 0", 2'b00, 3'd0, 1'b0, 1'b1, 8'h00, 1, 0, 1, 0);
      trial("R5 lock bit block 2", 2'b01, 3'd2, 1'b1, 1'b1, 8'h04, 1, 0, 1, 0);
      trial("R5 other block locked only", 2'b00, 3'd2, 1'b1, 1'b1, 8'hFB, 1, 0, 1, 0);
      trial("R6 supply low", 2'b00, 3'd1, 1'b1, 1'b1, 8'h00, 0, 0, 1, 0);
      trial("R7 mux oe low", 2'b00, 3'd1, 1'b1, 1'b1, 8'h00, 1, 1, 0, 3);
      trial("R7 mux we high", 2'b00, 3'd1, 1'b1, 1'b1, 8'h00, 1, 1, 1, 0);
      trial("R7 strobes ignored outside mux", 2'b00, 3'd1, 1'b1, 1'b1, 8'h00, 1, 0, 0, 0);
      trial("R8 one-sample pulse", 2'b00, 3'd1, 1'b1, 1'b1, 8'h00, 1, 1, 1, 1);
      trial("R8 minimum pulse", 2'b00, 3'd1, 1'b1, 1'b1, 8'h00, 1, 1, 1, 2);
      trial("R9 chip erase clear", 2'b10, 3'd0, 1'b1, 1'b1, 8'h00, 1, 0, 1, 0);
      trial("R9 chip erase one lock", 2'b10, 3'd0, 1'b1, 1'b1, 8'h20, 1, 0, 1, 0);
      trial("R9 chip erase boot pin", 2'b10, 3'd0, 1'b0, 1'b1, 8'h00, 1, 0, 1, 0);
      trial("R10 reserved op", 2'b11, 3'd1, 1'b1, 1'b1, 8'h00, 1, 0, 1, 0);
      @(negedge clk);
      check("R2 idle cycle", 1'b0, 1'b0);

      for (int n = 0; n < 400; n++) begin
         logic [7:0] lk;
         lk = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
         trial("R2 random", 2'($urandom), 3'($urandom), ($urandom % 4 != 0),
               ($urandom % 4 != 0), lk, ($urandom % 8 != 0), 1'($urandom),
               ($urandom % 5 != 0), int'($urandom % 4));
      end
      @(negedge clk);
      check("R2 idle after random", 1'b0, 1'b0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule